// File: doc/BRIEF.md
# SDRAM Refresh Request Timer

This block paces refresh for a single-data-rate SDRAM controller. A host programs a 16-bit refresh interval through a three-bit command port. The interval is taken from the address bus, which is registered one cycle so that it lines up with the decoded command. A down-counter runs from that interval. When it reaches zero, the block raises a refresh request. The request stays up until the lower-level sequencer that issues the real refresh command acknowledges it, and the counter then starts over from the programmed interval.

The block also acknowledges the interval-load command on its command-acknowledge output, which the host can watch. The same output passes through an acknowledge coming from a lower module. When the burst-length setting selects page mode (value 0000), counting is frozen and no new request is produced.

Top module: `sdr_refresh_timer`

## Requirements
- R1: While rst_n is low, refresh_req and cmd_ack are 0 and the internal interval and count are zero. Because the count starts at zero, the first clock edge after reset with a non-page burst setting raises refresh_req.
- R2: Command code 3'b111 sampled on cmd_code loads the refresh interval from bits [15:0] of the address registered one cycle earlier. Address bits above bit 15 are ignored. A new interval is used from the next reload of the counter.
- R3: The internal load strobe is set only if it was low on the previous cycle. A load command held for several cycles therefore produces cmd_ack on every other cycle.
- R4: cmd_ack rises on the second clock edge after a load command is sampled. It is high for exactly one cycle and is never high on two consecutive cycles.
- R5: A high lower_ack is passed to cmd_ack on the next edge, subject to the same one-cycle rule. A held lower_ack gives a pulse every other cycle.
- R6: Once raised, refresh_req stays high until refresh_ack is sampled high, and it falls on that edge provided the count is not zero. While the request is pending, the counter reloads from the interval on every edge.
- R7: With interval N loaded and a non-page burst setting, refresh_req rises N+1 clock edges after the edge on which it fell.
- R8: Burst setting 4'b0000 (page mode) holds the counter and prevents any new request. Any other burst value counts normally. When page mode ends, counting resumes from the held value.
- R9: Command codes other than 3'b111 neither change the interval nor cause cmd_ack.
- R10: addr_aligned equals addr_in delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 3 | Host command code; 3'b111 loads the refresh interval |
| addr_in | input | ADDR_W (23) | Host address; low PERIOD_W bits carry the interval |
| lower_ack | input | 1 | Acknowledge from a lower module, passed to cmd_ack |
| refresh_ack | input | 1 | Sequencer accepted the refresh request |
| burst_len | input | BL_W (4) | Burst-length setting; 0000 selects page mode |
| addr_aligned | output | ADDR_W (23) | Address registered to align with decoded command |
| refresh_req | output | 1 | Held refresh request |
| cmd_ack | output | 1 | One-cycle command acknowledge |

## Verification
The bench builds the block with its defaults: a 23-bit address, a 16-bit interval and a 4-bit burst setting. These values let the bench drive address words with bits set above bit 15 and check that those bits are dropped. Small interval values (4, 5, 12) keep each request-to-request gap to a few cycles, so the N+1 spacing, the alternating acknowledge under a held command and the resumption after page mode are all measured within a short run. The cold start from a zero count, where the 16-bit counter wraps on the edge that raises the request, is also covered.

// File: rtl/sdr_refresh_timer_pkg.sv
package sdr_refresh_timer_pkg;

   localparam int CMD_W         = 3;
   localparam int DEF_ADDR_W    = 23;
   localparam int DEF_PERIOD_W  = 16;
   localparam int DEF_BL_W      = 4;

   typedef logic [CMD_W-1:0] cmd_t;

   localparam cmd_t CMD_IDLE        = 3'b000;
   localparam cmd_t CMD_PERIOD_LOAD = 3'b111;

   localparam logic [DEF_BL_W-1:0] BL_PAGE_MODE = '0;

endpackage

// File: rtl/rft_cmd_decode.sv
module rft_cmd_decode
   import sdr_refresh_timer_pkg::*;
#(
   parameter int   ADDR_W    = DEF_ADDR_W,
   parameter cmd_t LOAD_CODE = CMD_PERIOD_LOAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_t              cmd_code,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              load_stb,
   output logic [ADDR_W-1:0] addr_q
);

   logic hit;

   assign hit = (cmd_code == LOAD_CODE);

   // Address stage keeps the word in step with the registered strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else begin
         addr_q <= addr_in;
      end
   end

   // Strobe may only be set when it was clear: a held command alternates.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_stb <= 1'b0;
      end else begin
         load_stb <= hit && !load_stb;
      end
   end

endmodule

// File: rtl/rft_ack_gen.sv
module rft_ack_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic load_stb,
   input  logic lower_ack,
   output logic cmd_ack
);

   logic cause;

   assign cause = load_stb || lower_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_ack <= 1'b0;
      end else begin
         cmd_ack <= cause && !cmd_ack;
      end
   end

endmodule

// File: rtl/rft_refresh_counter.sv
module rft_refresh_counter
   import sdr_refresh_timer_pkg::*;
#(
   parameter int PERIOD_W   = DEF_PERIOD_W,
   parameter int BL_W       = DEF_BL_W,
   parameter bit PAGE_GATE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_stb,
   input  logic [PERIOD_W-1:0] period_in,
   input  logic [BL_W-1:0]     burst_len,
   input  logic                refresh_ack,
   output logic                refresh_req
);

   localparam logic [PERIOD_W-1:0] CNT_ONE  = PERIOD_W'(1);
   localparam logic [PERIOD_W-1:0] CNT_ZERO = '0;

   logic [PERIOD_W-1:0] period_q;
   logic [PERIOD_W-1:0] cnt_q;
   logic                zero_q;
   logic                run;
   logic                at_zero;

   generate
      if (PAGE_GATE) begin : g_page_gate
         assign run = (burst_len != BL_W'(0));
      end else begin : g_free_run
         logic unused_bl;
         assign unused_bl = ^burst_len;
         assign run = 1'b1;
      end
   endgenerate

   assign at_zero = (cnt_q == CNT_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
      end else if (load_stb) begin
         period_q <= period_in;
      end
   end

   // Reload has priority over counting while a request is outstanding.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (zero_q) begin
         cnt_q <= period_q;
      end else if (run) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_q <= 1'b0;
      end else if (at_zero && run) begin
         zero_q <= 1'b1;
      end else if (refresh_ack) begin
         zero_q <= 1'b0;
      end
   end

   assign refresh_req = zero_q;

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer
   import sdr_refresh_timer_pkg::*;
#(
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int PERIOD_W  = DEF_PERIOD_W,
   parameter int BL_W      = DEF_BL_W,
   parameter bit PAGE_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_code,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              lower_ack,
   input  logic              refresh_ack,
   input  logic [BL_W-1:0]   burst_len,
   output logic [ADDR_W-1:0] addr_aligned,
   output logic              refresh_req,
   output logic              cmd_ack
);

   generate
      if (ADDR_W < PERIOD_W) begin : g_bad_addr_w
         $error("sdr_refresh_timer: ADDR_W must cover PERIOD_W");
      end
      if (PERIOD_W < 2) begin : g_bad_period_w
         $error("sdr_refresh_timer: PERIOD_W too small");
      end
      if (BL_W < 1) begin : g_bad_bl_w
         $error("sdr_refresh_timer: BL_W must be positive");
      end
   endgenerate

   logic load_stb;

   rft_cmd_decode #(
      .ADDR_W    (ADDR_W),
      .LOAD_CODE (CMD_PERIOD_LOAD)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_code (cmd_code),
      .addr_in  (addr_in),
      .load_stb (load_stb),
      .addr_q   (addr_aligned)
   );

   rft_ack_gen u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_stb  (load_stb),
      .lower_ack (lower_ack),
      .cmd_ack   (cmd_ack)
   );

   rft_refresh_counter #(
      .PERIOD_W  (PERIOD_W),
      .BL_W      (BL_W),
      .PAGE_GATE (PAGE_GATE)
   ) u_counter (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_stb    (load_stb),
      .period_in   (addr_aligned[PERIOD_W-1:0]),
      .burst_len   (burst_len),
      .refresh_ack (refresh_ack),
      .refresh_req (refresh_req)
   );

endmodule

// File: rtl/sdr_refresh_timer_chk.sv
module sdr_refresh_timer_chk
   import sdr_refresh_timer_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic [2:0]          cmd_code,
   input logic [DEF_BL_W-1:0] burst_len,
   input logic                lower_ack,
   input logic                refresh_ack,
   input logic                load_stb,
   input logic                cmd_ack,
   input logic                refresh_req
);

   // R2: a strobe is only produced by the load code
   assert_stb_from_load_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> $past(cmd_code) == CMD_PERIOD_LOAD);

   // R3: the strobe never stays high across two cycles
   assert_stb_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> !load_stb);

   // R4: acknowledge is a single-cycle pulse
   assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ack |=> !cmd_ack);

   // R5: acknowledge always has a strobe or lower acknowledge behind it
   assert_ack_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_ack) |-> $past(load_stb || lower_ack));

   // R6: request is held until acknowledged
   assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_req && !refresh_ack) |=> refresh_req);

   // R8: no new request rises out of page mode
   assert_no_rise_in_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refresh_req) |-> $past(burst_len) != BL_PAGE_MODE);

endmodule

bind sdr_refresh_timer sdr_refresh_timer_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_code    (cmd_code),
   .burst_len   (burst_len),
   .lower_ack   (lower_ack),
   .refresh_ack (refresh_ack),
   .load_stb    (load_stb),
   .cmd_ack     (cmd_ack),
   .refresh_req (refresh_req)
);

// File: tb/sdr_refresh_timer_tb_top.sv
`timescale 1ns/1ps
module sdr_refresh_timer_tb_top;

   localparam int AW = 23;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    cmd_code;
   logic [AW-1:0] addr_in;
   logic          lower_ack;
   logic          refresh_ack;
   logic [BW-1:0] burst_len;
   logic [AW-1:0] addr_aligned;
   logic          refresh_req;
   logic          cmd_ack;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 0;

   always #2 clk = ~clk;

   sdr_refresh_timer dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_code     (cmd_code),
      .addr_in      (addr_in),
      .lower_ack    (lower_ack),
      .refresh_ack  (refresh_ack),
      .burst_len    (burst_len),
      .addr_aligned (addr_aligned),
      .refresh_req  (refresh_req),
      .cmd_ack      (cmd_ack)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model, updated from values held before each edge
   bit m_stb, m_ack, m_req;
   int m_addr, m_period, m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_stb = 0; m_ack = 0; m_req = 0;
         m_addr = 0; m_period = 0; m_cnt = 0;
      end else begin
         bit n_stb, n_ack, n_req;
         int n_period, n_cnt;
         n_stb    = (cmd_code == 3'b111) && !m_stb;
         n_ack    = (m_stb || lower_ack) && !m_ack;
         n_period = m_stb ? (m_addr & 32'hFFFF) : m_period;
         if (m_req)               n_cnt = m_period;
         else if (burst_len != 0) n_cnt = (m_cnt + 65535) % 65536;
         else                     n_cnt = m_cnt;
         if (m_cnt == 0 && burst_len != 0) n_req = 1;
         else if (refresh_ack)             n_req = 0;
         else                              n_req = m_req;
         m_addr   = int'(addr_in);
         m_stb    = n_stb;
         m_ack    = n_ack;
         m_period = n_period;
         m_cnt    = n_cnt;
         m_req    = n_req;
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         check(refresh_req == m_req, "R6 model refresh_req", refresh_req, m_req);
         check(cmd_ack == m_ack, "R4 model cmd_ack", cmd_ack, m_ack);
         check(int'(addr_aligned) == m_addr, "R10 model addr_aligned", addr_aligned, m_addr);
      end
   end

   task automatic load_period(input logic [AW-1:0] word);
      cmd_code = 3'b111; addr_in = word;
      @(negedge clk);
      cmd_code = 3'b000;
      @(negedge clk);
      check(cmd_ack == 1'b1, "R4 ack after load", cmd_ack, 1);
      @(negedge clk);
      check(cmd_ack == 1'b0, "R4 ack one cycle", cmd_ack, 0);
   endtask

   // Acknowledge a pending request, then count edges until the next one
   task automatic measure_gap(input int n, input string tag);
      int k = 0;
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
      check(refresh_req == 1'b0, "R6 clear on ack", refresh_req, 0);
      while (!refresh_req && k < 2000) begin
         @(negedge clk);
         k++;
      end
      check(k == n + 1, tag, k, n + 1);
   endtask

   initial begin
      rst_n = 1'b0; cmd_code = 3'b000; addr_in = '0;
      lower_ack = 1'b0; refresh_ack = 1'b0; burst_len = 4'd1;
      repeat (3) @(negedge clk);
      check(refresh_req == 1'b0, "R1 req in reset", refresh_req, 0);
      check(cmd_ack == 1'b0, "R1 ack in reset", cmd_ack, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(refresh_req == 1'b1, "R1 first edge raises request", refresh_req, 1);

      load_period(23'd5);
      measure_gap(5, "R7 gap interval 5");
      measure_gap(5, "R7 gap interval 5 repeat");

      // R6: held without acknowledge
      repeat (20) @(negedge clk);
      check(refresh_req == 1'b1, "R6 held without ack", refresh_req, 1);

      // R2: upper address bits ignored, burst value 1000 also counts (R8)
      burst_len = 4'b1000;
      load_period(23'h7F000C);
      measure_gap(12, "R2 interval from low bits");

      // R9: other command code does not load or acknowledge
      begin
         int acks = 0;
         cmd_code = 3'b011; addr_in = 23'd3;
         repeat (2) begin @(negedge clk); acks += cmd_ack; end
         cmd_code = 3'b000;
         repeat (3) begin @(negedge clk); acks += cmd_ack; end
         check(acks == 0, "R9 no ack for other code", acks, 0);
      end
      measure_gap(12, "R9 interval unchanged");

      // R3: held load command yields alternating acknowledge
      begin
         int acks = 0;
         cmd_code = 3'b111; addr_in = 23'd4;
         repeat (6) begin @(negedge clk); acks += cmd_ack; end
         cmd_code = 3'b000;
         repeat (2) begin @(negedge clk); acks += cmd_ack; end
         check(acks == 3, "R3 held load acks", acks, 3);
      end
      measure_gap(4, "R7 gap interval 4");

      // R5: held lower acknowledge
      begin
         int acks = 0;
         lower_ack = 1'b1;
         repeat (4) begin @(negedge clk); acks += cmd_ack; end
         lower_ack = 1'b0;
         repeat (2) begin @(negedge clk); acks += cmd_ack; end
         check(acks == 2, "R5 lower ack pass-through", acks, 2);
      end

      // R8: page mode freezes counting
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
      burst_len = 4'b0000;
      begin
         int highs = 0;
         repeat (40) begin @(negedge clk); highs += refresh_req; end
         check(highs == 0, "R8 no request in page mode", highs, 0);
      end
      burst_len = 4'd2;
      begin
         int k = 0;
         while (!refresh_req && k < 2000) begin @(negedge clk); k++; end
         check(k == 5, "R8 resume from held count", k, 5);
      end

      repeat (4) @(negedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         check(1'b0, "watchdog expired", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule